// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block sits between a processor core's reset logic and its memory bus. It brings the core up without running a single instruction. Once reset is released, it issues two word reads on a valid/ready request channel. The word at address 0x00000000 becomes the initial stack pointer. The word at address 0x00000004 becomes the initial program counter, which is the reset handler entry. After both words have arrived it raises a start signal, and the core may then begin instruction fetch. A bus error on either read parks the sequencer in a lockup state.

The block also holds a table-base register that software writes. The register is always aligned to 128 bytes. Later exception vector lookups add four times the exception number to it, so an application linked above a bootloader can point lookups at its own table. At the end of reset the block also samples a boot-map select input. From that sample it drives a one-hot enable that picks which memory backs the low address region, and only one memory is enabled at a time.

Request channel rules: the sequencer raises `mem_req_valid` and holds it, with `mem_req_addr` unchanged, until it sees `mem_req_ready` high on a rising edge. It keeps at most one read outstanding. It waits any number of cycles for the matching `mem_rsp_valid` strobe. A response that arrives while no read is outstanding is ignored.

Top module: `boot_vector_fetch`

## Requirements
- R1: While reset is asserted and in the first cycle after it: `core_start`, `mem_req_valid` and `locked_up` are 0; `sp_out`, `pc_out`, `entry_lsb` and `vtor_value` are 0; `low_region_en` is all zero.
- R2: The first read requested after reset has address 0x00000000, and its response data appears on `sp_out`.
- R3: The second read has address 0x00000004. It is requested only after the first response, and its data sets `pc_out`.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with a stable address. Any number of ready-wait and response-wait cycles is tolerated, and no third read is ever issued.
- R5: `pc_out` bit 0 is always 0, and `entry_lsb` carries bit 0 of the fetched reset-handler word.
- R6: `core_start` rises in the cycle after the second response is accepted without error. It then stays high until reset.
- R7: If either response has `mem_rsp_err` set, `locked_up` goes high and stays high. `core_start` never rises, and no further read is issued.
- R8: A write through `vtor_wr_en`/`vtor_wr_data` shows on `vtor_value` one cycle later, with bits 6:0 forced to 0.
- R9: `exc_vec_addr` equals `vtor_value + 4*exc_num` combinationally. A lookup in the same cycle as a write uses the old table base.
- R10: `boot_sel` is sampled on the first clock edge after reset release. From then on `low_region_en` is the one-hot code for that source (bit i for value i), and it stays fixed until the next reset. A value of `NSRC` or above selects source 0.
- R11: Asserting reset in the middle of a fetch drops the request and the start signal. After release, the sequence starts again from address 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_sel | input | SEL_W (2) | Boot-map source select, sampled after reset |
| low_region_en | output | NSRC (3) | One-hot enable of the memory backing the low region |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W (32) | Read word address |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_err | input | 1 | Read response carries a bus error |
| mem_rsp_data | input | DATA_W (32) | Read response data |
| sp_out | output | DATA_W (32) | Initial stack pointer |
| pc_out | output | DATA_W (32) | Initial program counter, bit 0 cleared |
| entry_lsb | output | 1 | Bit 0 of the fetched reset-handler word |
| core_start | output | 1 | Core may begin instruction fetch |
| locked_up | output | 1 | Fetch failed on a bus error |
| vtor_wr_en | input | 1 | Table-base register write strobe |
| vtor_wr_data | input | ADDR_W (32) | Table-base write value |
| vtor_value | output | ADDR_W (32) | Current table base, 128-byte aligned |
| exc_num | input | EXC_W (9) | Exception number to look up |
| exc_vec_addr | output | ADDR_W (32) | Address of that exception's vector |

## Verification
Two functions can act in the same cycle: a table-base write and an exception vector lookup. The bench drives a write strobe and a new exception number on the same falling edge. Before the next rising edge, it checks that the lookup address is built from the old base. After that edge, it checks that the address is built from the new, aligned base. A second collision, reset arriving while a read is outstanding, is provoked by stalling the response. The bench then checks that the restarted sequence begins again at address zero.

// File: rtl/bvf_pkg.sv
package bvf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE_RESET = 3'd0,
    ST_REQ_SP     = 3'd1,
    ST_WAIT_SP    = 3'd2,
    ST_REQ_PC     = 3'd3,
    ST_WAIT_PC    = 3'd4,
    ST_RUN        = 3'd5,
    ST_LOCKUP     = 3'd6
  } bvf_state_e;

  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/bvf_seq_fsm.sv
module bvf_seq_fsm #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] sp_val,
  output logic [DATA_W-1:0] pc_val,
  output logic              lsb_val,
  output logic              start,
  output logic              lockup
);
  import bvf_pkg::*;

  localparam logic [ADDR_W-1:0] SP_ADDR = '0;
  localparam logic [ADDR_W-1:0] PC_ADDR = ADDR_W'(WORD_BYTES);

  bvf_state_e state_q, state_d;
  logic [DATA_W-1:0] sp_q, pc_q;
  logic              lsb_q;

  // next-state decode
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE_RESET: state_d = ST_REQ_SP;
      ST_REQ_SP:     if (req_ready) state_d = ST_WAIT_SP;
      ST_WAIT_SP:    if (rsp_valid) state_d = rsp_err ? ST_LOCKUP : ST_REQ_PC;
      ST_REQ_PC:     if (req_ready) state_d = ST_WAIT_PC;
      ST_WAIT_PC:    if (rsp_valid) state_d = rsp_err ? ST_LOCKUP : ST_RUN;
      ST_RUN:        state_d = ST_RUN;
      ST_LOCKUP:     state_d = ST_LOCKUP;
      default:       state_d = ST_LOCKUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE_RESET;
      sp_q    <= '0;
      pc_q    <= '0;
      lsb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WAIT_SP && rsp_valid && !rsp_err) begin
        sp_q <= rsp_data;
      end
      if (state_q == ST_WAIT_PC && rsp_valid && !rsp_err) begin
        pc_q  <= {rsp_data[DATA_W-1:1], 1'b0};
        lsb_q <= rsp_data[0];
      end
    end
  end

  assign req_valid = (state_q == ST_REQ_SP) || (state_q == ST_REQ_PC);
  assign req_addr  = (state_q == ST_REQ_PC) ? PC_ADDR : SP_ADDR;
  assign sp_val    = sp_q;
  assign pc_val    = pc_q;
  assign lsb_val   = lsb_q;
  assign start     = (state_q == ST_RUN);
  assign lockup    = (state_q == ST_LOCKUP);

  // R4: a stalled request keeps its valid and its address
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R6: start is sticky once raised
  p_start_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> start);

  // R6: start rises only right after an accepted response
  p_start_after_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |-> $past(rsp_valid) && !$past(rsp_err));

  // R7: lockup is final and silent
  p_lock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |=> lockup && !req_valid && !start);
endmodule

// File: rtl/bvf_vtor_reg.sv
module bvf_vtor_reg #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ALIGN_BITS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base
);
  localparam int unsigned HI_W = ADDR_W - ALIGN_BITS;
  localparam logic [ADDR_W-1:0] KEEP_MASK = {{HI_W{1'b1}}, {ALIGN_BITS{1'b0}}};

  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     hi_q <= '0;
    else if (wr_en) hi_q <= wr_data[ADDR_W-1:ALIGN_BITS];
  end

  assign base = {hi_q, {ALIGN_BITS{1'b0}}};

  // R8: a write lands one cycle later, low bits dropped
  p_wr_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> base == ($past(wr_data) & KEEP_MASK));
endmodule

// File: rtl/bvf_vec_lookup.sv
module bvf_vec_lookup #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned EXC_W  = 9
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [EXC_W-1:0]  exc_num,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam int unsigned PAD_W = ADDR_W - EXC_W - 2;

  logic [ADDR_W-1:0] byte_off;

  assign byte_off = {{PAD_W{1'b0}}, exc_num, 2'b00};
  assign vec_addr = base + byte_off;
endmodule

// File: rtl/bvf_boot_map.sv
module bvf_boot_map #(
  parameter int unsigned NSRC  = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic [NSRC-1:0]  region_en
);
  logic             taken_q;
  logic [SEL_W-1:0] sel_q;
  logic [NSRC-1:0]  hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      sel_q   <= '0;
    end else if (!taken_q) begin
      taken_q <= 1'b1;
      sel_q   <= sel;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_dec
    assign hit[i] = (sel_q == SEL_W'(i));
  end

  assign region_en = !taken_q ? '0 : ((|hit) ? hit : NSRC'(1));

  // R10: one source at a time once sampled
  p_map_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q |-> $onehot(region_en));

  // R10: selection held until the next reset
  p_map_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q |=> $stable(region_en));
endmodule

// File: rtl/boot_vector_fetch.sv
module boot_vector_fetch #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned EXC_W      = 9,
  parameter int unsigned ALIGN_BITS = 7,
  parameter int unsigned NSRC       = 3,
  parameter int unsigned SEL_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  boot_sel,
  output logic [NSRC-1:0]   low_region_en,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [DATA_W-1:0] sp_out,
  output logic [DATA_W-1:0] pc_out,
  output logic              entry_lsb,
  output logic              core_start,
  output logic              locked_up,
  input  logic              vtor_wr_en,
  input  logic [ADDR_W-1:0] vtor_wr_data,
  output logic [ADDR_W-1:0] vtor_value,
  input  logic [EXC_W-1:0]  exc_num,
  output logic [ADDR_W-1:0] exc_vec_addr
);
  bvf_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (mem_req_valid),
    .req_ready (mem_req_ready),
    .req_addr  (mem_req_addr),
    .rsp_valid (mem_rsp_valid),
    .rsp_err   (mem_rsp_err),
    .rsp_data  (mem_rsp_data),
    .sp_val    (sp_out),
    .pc_val    (pc_out),
    .lsb_val   (entry_lsb),
    .start     (core_start),
    .lockup    (locked_up)
  );

  bvf_vtor_reg #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_vtor (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (vtor_wr_en),
    .wr_data (vtor_wr_data),
    .base    (vtor_value)
  );

  bvf_vec_lookup #(.ADDR_W(ADDR_W), .EXC_W(EXC_W)) u_lookup (
    .base     (vtor_value),
    .exc_num  (exc_num),
    .vec_addr (exc_vec_addr)
  );

  bvf_boot_map #(.NSRC(NSRC), .SEL_W(SEL_W)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (boot_sel),
    .region_en (low_region_en)
  );
endmodule

// File: tb/boot_vector_fetch_tb_top.sv
module boot_vector_fetch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  boot_sel = '0;
  logic [2:0]  low_region_en;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [31:0] sp_out, pc_out;
  logic        entry_lsb, core_start, locked_up;
  logic        vtor_wr_en = 1'b0;
  logic [31:0] vtor_wr_data = '0;
  logic [31:0] vtor_value;
  logic [8:0]  exc_num = '0;
  logic [31:0] exc_vec_addr;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  // memory model configuration
  logic [31:0] cfg_sp, cfg_pc;
  int          cfg_rdy = 0;
  int          cfg_lat = 0;
  bit          cfg_esp = 0, cfg_epc = 0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_vector_fetch dut_i (
    .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel), .low_region_en(low_region_en),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .sp_out(sp_out), .pc_out(pc_out), .entry_lsb(entry_lsb), .core_start(core_start),
    .locked_up(locked_up), .vtor_wr_en(vtor_wr_en), .vtor_wr_data(vtor_wr_data),
    .vtor_value(vtor_value), .exc_num(exc_num), .exc_vec_addr(exc_vec_addr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model plus monitor: pops expected addresses as requests are accepted
  int          wait_cnt = 0;
  int          lat_cnt = 0;
  bit          pend = 0;
  logic [31:0] pend_addr = '0;
  logic [31:0] held_addr = '0;
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      wait_cnt = 0;
      pend = 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      if (mem_req_ready) begin
        // accepted on the edge just passed
        mem_req_ready <= 1'b0;
        pend = 1;
        lat_cnt = cfg_lat;
        pend_addr = held_addr;
        wait_cnt = 0;
      end else if (pend) begin
        if (lat_cnt == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= (pend_addr == 32'h4) ? cfg_pc : cfg_sp;
          mem_rsp_err   <= (pend_addr == 32'h4) ? cfg_epc : cfg_esp;
          pend = 0;
        end else lat_cnt--;
      end else if (mem_req_valid) begin
        if (wait_cnt > 0) chk("R4", "stalled address stable", mem_req_addr, held_addr);
        held_addr = mem_req_addr;
        if (wait_cnt >= cfg_rdy) begin
          mem_req_ready <= 1'b1;
          if (exp_q.size() == 0) begin
            chk("R4", "unexpected extra request", mem_req_addr, 32'hFFFF_FFFF);
          end else begin
            chk("R2/R3", "request address order", mem_req_addr, exp_q.pop_front());
          end
        end else wait_cnt++;
      end
    end
  end

  // watchdog
  initial begin
    wait (cyc > 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_boot(input logic [31:0] sp, input logic [31:0] pc, input int rdy,
                          input int lat, input bit esp, input bit epc);
    cfg_sp = sp; cfg_pc = pc; cfg_rdy = rdy; cfg_lat = lat; cfg_esp = esp; cfg_epc = epc;
    exp_q.delete();
    exp_q.push_back(32'h0);
    if (!esp) exp_q.push_back(32'h4);
    apply_reset();
    for (int i = 0; i < 400 && !(core_start || locked_up); i++) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    @(negedge clk); @(negedge clk);
    chk("R1", "core_start in reset", {31'b0, core_start}, 32'h0);
    chk("R1", "req_valid in reset", {31'b0, mem_req_valid}, 32'h0);
    chk("R1", "locked_up in reset", {31'b0, locked_up}, 32'h0);
    chk("R1", "sp in reset", sp_out, 32'h0);
    chk("R1", "vtor in reset", vtor_value, 32'h0);
    chk("R1", "region in reset", {29'b0, low_region_en}, 32'h0);

    // R2 R3 R5 R6 R10: fast memory, boot_sel 2
    boot_sel = 2'd2;
    run_boot(32'h2000_1000, 32'h0000_0101, 0, 0, 0, 0);
    chk("R6", "start after boot", {31'b0, core_start}, 32'h1);
    chk("R2", "sp loaded", sp_out, 32'h2000_1000);
    chk("R3", "pc loaded", pc_out, 32'h0000_0100);
    chk("R5", "entry lsb set", {31'b0, entry_lsb}, 32'h1);
    chk("R10", "region one-hot sel 2", {29'b0, low_region_en}, 32'h4);
    boot_sel = 2'd0;
    repeat (10) @(negedge clk);
    chk("R6", "start stays high", {31'b0, core_start}, 32'h1);
    chk("R10", "region held after sel change", {29'b0, low_region_en}, 32'h4);
    chk("R4", "no request after boot", exp_q.size(), 32'h0);

    // R4 R5: slow ready and slow response, out-of-range select
    boot_sel = 2'd3;
    run_boot(32'h1FFF_FFF0, 32'h0800_0244, 3, 5, 0, 0);
    chk("R6", "start after slow boot", {31'b0, core_start}, 32'h1);
    chk("R2", "sp slow", sp_out, 32'h1FFF_FFF0);
    chk("R3", "pc slow", pc_out, 32'h0800_0244);
    chk("R5", "entry lsb clear", {31'b0, entry_lsb}, 32'h0);
    chk("R10", "out-of-range picks source 0", {29'b0, low_region_en}, 32'h1);

    // R7: error on stack-pointer read
    boot_sel = 2'd1;
    run_boot(32'hDEAD_0000, 32'h0000_0201, 1, 2, 1, 0);
    repeat (8) @(negedge clk);
    chk("R7", "lockup on first read", {31'b0, locked_up}, 32'h1);
    chk("R7", "no start on first error", {31'b0, core_start}, 32'h0);
    chk("R7", "no second read issued", exp_q.size(), 32'h0);

    // R7: error on program-counter read
    run_boot(32'h2000_0800, 32'h0000_0301, 0, 1, 0, 1);
    repeat (8) @(negedge clk);
    chk("R7", "lockup on second read", {31'b0, locked_up}, 32'h1);
    chk("R7", "no start on second error", {31'b0, core_start}, 32'h0);
    chk("R7", "no request after lockup", {31'b0, mem_req_valid}, 32'h0);

    // R11: reset while the first read is outstanding
    cfg_sp = 32'h1111_1110; cfg_lat = 30; cfg_rdy = 0; cfg_esp = 0; cfg_epc = 0;
    exp_q.delete();
    exp_q.push_back(32'h0);
    apply_reset();
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "start low after mid reset", {31'b0, core_start}, 32'h0);
    chk("R11", "request dropped", {31'b0, mem_req_valid}, 32'h0);
    chk("R11", "first read was issued", exp_q.size(), 32'h0);
    run_boot(32'h3000_0000, 32'h0000_0401, 2, 3, 0, 0);
    chk("R11", "restart completes", {31'b0, core_start}, 32'h1);
    chk("R11", "restart sp", sp_out, 32'h3000_0000);
    chk("R11", "restart pc", pc_out, 32'h0000_0400);

    // R8: table-base writes
    @(negedge clk);
    vtor_wr_en = 1'b1; vtor_wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    vtor_wr_en = 1'b0;
    chk("R8", "all-ones write aligned", vtor_value, 32'hFFFF_FF80);
    vtor_wr_en = 1'b1; vtor_wr_data = 32'h0000_007F;
    @(negedge clk);
    vtor_wr_en = 1'b0;
    chk("R8", "low-bit-only write reads zero", vtor_value, 32'h0);
    vtor_wr_en = 1'b1; vtor_wr_data = 32'h0000_8123;
    @(negedge clk);
    vtor_wr_en = 1'b0;
    chk("R8", "base aligned", vtor_value, 32'h0000_8100);

    // R9: lookups, including one colliding with a write
    exc_num = 9'd5;
    #1 chk("R9", "lookup n=5", exc_vec_addr, 32'h0000_8114);
    @(negedge clk);
    vtor_wr_en = 1'b1; vtor_wr_data = 32'h0002_0040; exc_num = 9'd3;
    #1 chk("R9", "same-cycle lookup uses old base", exc_vec_addr, 32'h0000_810C);
    @(negedge clk);
    vtor_wr_en = 1'b0;
    chk("R9", "lookup uses new base", exc_vec_addr, 32'h0002_000C);
    exc_num = 9'd511;
    #1 chk("R9", "lookup max number", exc_vec_addr, 32'h0002_07FC);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule